// File: doc/BRIEF.md
# Translation Cache with Page-Table Walker

This block translates 8-bit virtual addresses into physical addresses. It uses a four-entry fully associative store of recent page translations. An address splits into a 4-bit virtual page number in bits [7:4] and a 4-bit page offset in bits [3:0], so each page is 16 bytes.

When a lookup hits and the access type is allowed, the block returns the physical page number joined with the unchanged offset. When a lookup misses, a walker inside the block fetches one page-table byte over a memory read port. The byte's address is the base input plus the page number. The walker then either reports a fault, or installs the translation and tells the requester to try again. The repeated request then hits.

Control is a four-state machine:

- **ST_IDLE** accepts a request. On a hit it moves to ST_REPLY; on a miss it moves to ST_PT_REQ.
- **ST_PT_REQ** issues the one-cycle read request and always moves to ST_PT_WAIT.
- **ST_PT_WAIT** holds until the read data is valid, classifies the entry (and installs it if it is usable), and moves to ST_REPLY.
- **ST_REPLY** presents the result for one cycle and always returns to ST_IDLE.

Top module: `xlat_cache`

## Requirements
- R1: After reset, all four store entries are invalid, and `busy`, `resp_done`, `resp_retry`, `mem_rd_req`, `resp_paddr` and `resp_fault` are all 0. The first lookup of any page therefore misses.
- R2: A request is taken when `req_valid` is high and `busy` is low. On a hit whose access is allowed, the next cycle has `resp_done`=1, `resp_fault`=0 and `resp_paddr` = {stored PFN, `req_vaddr[3:0]`}. `resp_paddr` is 0 in every other cycle.
- R3: A read needs the readable flag and a write (`req_write`=1) needs the writable flag. A hit that fails this check gives `resp_done`=1 with `resp_fault`=1 in the next cycle, and issues no memory read.
- R4: On a miss, `mem_rd_req` is high for exactly one cycle, one cycle after the request is taken. During that cycle `mem_rd_addr` equals (`ptbr` + page number) modulo 256, with `ptbr` sampled when the request is taken.
- R5: A page-table byte is laid out as: bit 7 valid, bit 6 readable, bit 5 writable, bit 4 unused, bits [3:0] PFN. If its valid bit is 0, the cycle after `mem_rd_valid` has `resp_done`=1 and `resp_fault`=2, and nothing is installed, so the same page misses again.
- R6: If the byte is valid but forbids the requested access, the result is `resp_done`=1 with `resp_fault`=1, and nothing is installed.
- R7: Otherwise, the translation is installed and the cycle after `mem_rd_valid` has `resp_retry`=1 with `resp_done`=0. A repeated identical request then hits.
- R8: A fill goes into the lowest-numbered invalid entry if there is one. Otherwise it goes into the entry selected by a round-robin pointer. The pointer is 0 after reset and advances by one (mod 4) on every fill.
- R9: `busy` is high from the cycle after a miss or hit is taken up to and including the reply cycle. `req_valid` has no effect while `busy` is high, and memory reads are issued only by taken requests.
- R10: From reset, reads of addresses 100, 104, …, 136 (each miss retried until it hits) give first-attempt outcomes miss, hit, hit, miss, hit, hit, hit, miss, hit, hit. A second pass without reset gives ten hits.
- R11: `resp_done` or `resp_retry` lasts exactly one cycle, a nonzero `resp_fault` appears only with `resp_done`, and `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptbr | input | 8 | Page-table base address |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 8 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| busy | output | 1 | A lookup is in progress; requests are ignored |
| resp_done | output | 1 | Final result (translation or fault) this cycle |
| resp_retry | output | 1 | Translation installed; repeat the request |
| resp_paddr | output | 8 | Physical address on a successful hit, else 0 |
| resp_fault | output | 2 | 0 none, 1 protection, 2 segmentation |
| mem_rd_req | output | 1 | One-cycle page-table read request |
| mem_rd_addr | output | 8 | Page-table byte address |
| mem_rd_valid | input | 1 | Read data valid (latency of one or more cycles) |
| mem_rd_data | input | 8 | Page-table byte |

## Verification
A hit result is due in the cycle after the request is taken. A miss raises `mem_rd_req` in that same following cycle, and the fault or retry appears in the cycle after `mem_rd_valid`. `busy` falls in the cycle after the reply.

The bench advances a behavioural model on each rising edge, using only the inputs it drove. It compares every output on the falling edge, so each result is checked in exactly the cycle it is due. Memory latency varies from one to three cycles so the wait state is exercised at several lengths. Directed sequences then check the outcome of each request, including replacement order and base-address wrap.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W     = 8;
    localparam int OFF_W    = 4;
    localparam int VPN_W    = VA_W - OFF_W;
    localparam int PFN_W    = 4;
    localparam int PA_W     = PFN_W + OFF_W;
    localparam int PTE_W    = 8;
    localparam int PTE_VBIT = 7;
    localparam int PTE_RBIT = 6;
    localparam int PTE_WBIT = 5;
    localparam int PROT_W   = 2;   // {readable, writable}

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PROT = 2'd1,
        FLT_SEG  = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PT_REQ,
        ST_PT_WAIT,
        ST_REPLY
    } walk_st_e;

    function automatic logic access_ok(input logic [PROT_W-1:0] prot, input logic is_write);
        return is_write ? prot[0] : prot[1];
    endfunction
endpackage

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PROT_W-1:0] lk_prot,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PROT_W-1:0] fill_prot
);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    logic [N_ENT-1:0]             valid_vec;
    logic [N_ENT-1:0]             hit_vec;
    logic [N_ENT-1:0][PFN_W-1:0]  pfn_vec;
    logic [N_ENT-1:0][PROT_W-1:0] prot_vec;
    logic [IDX_W-1:0]             rr_q;
    logic [IDX_W-1:0]             victim;

    // lowest free slot wins, otherwise the round-robin slot
    always_comb begin
        victim = rr_q;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!valid_vec[i]) victim = IDX_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fill_en) begin
            rr_q <= (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic              v_q;
        logic [VPN_W-1:0]  tag_q;
        logic [PFN_W-1:0]  pfn_q;
        logic [PROT_W-1:0] prot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q    <= 1'b0;
                tag_q  <= '0;
                pfn_q  <= '0;
                prot_q <= '0;
            end else if (fill_en && (victim == IDX_W'(g))) begin
                v_q    <= 1'b1;
                tag_q  <= fill_vpn;
                pfn_q  <= fill_pfn;
                prot_q <= fill_prot;
            end
        end

        assign valid_vec[g] = v_q;
        assign hit_vec[g]   = v_q && (tag_q == lk_vpn);
        assign pfn_vec[g]   = pfn_q;
        assign prot_vec[g]  = prot_q;
    end

    always_comb begin
        lk_pfn  = '0;
        lk_prot = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit_vec[i]) begin
                lk_pfn  |= pfn_vec[i];
                lk_prot |= prot_vec[i];
            end
        end
    end

    assign lk_hit = |hit_vec;

    AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R8
endmodule

// File: rtl/xlat_walk_ctrl.sv
module xlat_walk_ctrl
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [VA_W-1:0]   ptbr,
    output logic [VPN_W-1:0]  lk_vpn,
    input  logic              lk_hit,
    input  logic [PFN_W-1:0]  lk_pfn,
    input  logic [PROT_W-1:0] lk_prot,
    output logic              fill_en,
    output logic [VPN_W-1:0]  fill_vpn,
    output logic [PFN_W-1:0]  fill_pfn,
    output logic [PROT_W-1:0] fill_prot,
    output logic              mem_rd_req,
    output logic [VA_W-1:0]   mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [PTE_W-1:0]  mem_rd_data,
    output logic              busy,
    output logic              resp_done,
    output logic              resp_retry,
    output logic [PA_W-1:0]   resp_paddr,
    output logic [1:0]        resp_fault
);
    walk_st_e          st_q, st_d;
    logic [VPN_W-1:0]  vpn_in;
    logic [OFF_W-1:0]  off_in;
    logic              accept;
    logic              pte_back;
    logic              pte_valid;
    logic [PROT_W-1:0] pte_prot;
    logic [PFN_W-1:0]  pte_pfn;
    logic              pte_unused_bit;
    logic              pte_ok;
    logic              in_reply;

    logic [VPN_W-1:0]  vpn_q;
    logic              wr_q;
    logic [VA_W-1:0]   pt_addr_q;
    logic              rep_done_q;
    logic              rep_retry_q;
    logic [PA_W-1:0]   paddr_q;
    fault_e            fault_q;

    assign vpn_in         = req_vaddr[VA_W-1:OFF_W];
    assign off_in         = req_vaddr[OFF_W-1:0];
    assign accept         = (st_q == ST_IDLE) && req_valid;
    assign pte_valid      = mem_rd_data[PTE_VBIT];
    assign pte_prot       = {mem_rd_data[PTE_RBIT], mem_rd_data[PTE_WBIT]};
    assign pte_pfn        = mem_rd_data[PFN_W-1:0];
    assign pte_unused_bit = mem_rd_data[4];
    assign pte_back       = (st_q == ST_PT_WAIT) && mem_rd_valid;
    assign pte_ok         = pte_valid && access_ok(pte_prot, wr_q);

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (accept) st_d = lk_hit ? ST_REPLY : ST_PT_REQ;
            ST_PT_REQ:  st_d = ST_PT_WAIT;
            ST_PT_WAIT: if (mem_rd_valid) st_d = ST_REPLY;
            ST_REPLY:   st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // captured request and reply payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpn_q       <= '0;
            wr_q        <= 1'b0;
            pt_addr_q   <= '0;
            rep_done_q  <= 1'b0;
            rep_retry_q <= 1'b0;
            paddr_q     <= '0;
            fault_q     <= FLT_NONE;
        end else if (accept) begin
            vpn_q       <= vpn_in;
            wr_q        <= req_write;
            pt_addr_q   <= ptbr + {{(VA_W-VPN_W){1'b0}}, vpn_in};
            rep_done_q  <= lk_hit;
            rep_retry_q <= 1'b0;
            if (lk_hit && access_ok(lk_prot, req_write)) begin
                paddr_q <= {lk_pfn, off_in};
                fault_q <= FLT_NONE;
            end else begin
                paddr_q <= '0;
                fault_q <= lk_hit ? FLT_PROT : FLT_NONE;
            end
        end else if (pte_back) begin
            paddr_q <= '0;
            if (!pte_valid) begin
                rep_done_q  <= 1'b1;
                rep_retry_q <= 1'b0;
                fault_q     <= FLT_SEG;
            end else if (!pte_ok) begin
                rep_done_q  <= 1'b1;
                rep_retry_q <= 1'b0;
                fault_q     <= FLT_PROT;
            end else begin
                rep_done_q  <= 1'b0;
                rep_retry_q <= 1'b1;
                fault_q     <= FLT_NONE;
            end
        end
    end

    // outputs
    always_comb begin
        in_reply    = (st_q == ST_REPLY);
        busy        = (st_q != ST_IDLE);
        mem_rd_req  = (st_q == ST_PT_REQ);
        mem_rd_addr = pt_addr_q;
        resp_done   = in_reply && rep_done_q;
        resp_retry  = in_reply && rep_retry_q;
        resp_paddr  = in_reply ? paddr_q : '0;
        resp_fault  = in_reply ? fault_q : FLT_NONE;
        lk_vpn      = vpn_in;
        fill_en     = pte_back && pte_ok;
        fill_vpn    = vpn_q;
        fill_pfn    = pte_pfn;
        fill_prot   = pte_prot;
    end

    AST_MEMREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req); // R4
    AST_IDLE_NO_MEMREQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_req); // R9
    AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && lk_hit) |=> (resp_done && !mem_rd_req)); // R3
    AST_FAULT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_fault != 2'd0) |-> resp_done); // R11
    AST_REPLY_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done || resp_retry) |=> !busy); // R11
    AST_DONE_RETRY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_done && resp_retry)); // R7
    AST_FILL_THEN_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> resp_retry); // R7
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VA_W-1:0]  ptbr,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             busy,
    output logic             resp_done,
    output logic             resp_retry,
    output logic [PA_W-1:0]  resp_paddr,
    output logic [1:0]       resp_fault,
    output logic             mem_rd_req,
    output logic [VA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [PTE_W-1:0] mem_rd_data
);
    logic [VPN_W-1:0]  lk_vpn;
    logic              lk_hit;
    logic [PFN_W-1:0]  lk_pfn;
    logic [PROT_W-1:0] lk_prot;
    logic              fill_en;
    logic [VPN_W-1:0]  fill_vpn;
    logic [PFN_W-1:0]  fill_pfn;
    logic [PROT_W-1:0] fill_prot;

    xlat_store #(.N_ENT(N_ENT)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (lk_vpn),
        .lk_hit    (lk_hit),
        .lk_pfn    (lk_pfn),
        .lk_prot   (lk_prot),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn),
        .fill_pfn  (fill_pfn),
        .fill_prot (fill_prot)
    );

    xlat_walk_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .req_write    (req_write),
        .ptbr         (ptbr),
        .lk_vpn       (lk_vpn),
        .lk_hit       (lk_hit),
        .lk_pfn       (lk_pfn),
        .lk_prot      (lk_prot),
        .fill_en      (fill_en),
        .fill_vpn     (fill_vpn),
        .fill_pfn     (fill_pfn),
        .fill_prot    (fill_prot),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .busy         (busy),
        .resp_done    (resp_done),
        .resp_retry   (resp_retry),
        .resp_paddr   (resp_paddr),
        .resp_fault   (resp_fault)
    );
endmodule

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ptbr = 8'h80;
    logic       req_valid = 1'b0;
    logic [7:0] req_vaddr = 8'h00;
    logic       req_write = 1'b0;
    logic       mem_rd_valid = 1'b0;
    logic [7:0] mem_rd_data = 8'h00;
    logic       busy, resp_done, resp_retry, mem_rd_req;
    logic [7:0] resp_paddr, mem_rd_addr;
    logic [1:0] resp_fault;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    xlat_cache dut (
        .clk(clk), .rst_n(rst_n), .ptbr(ptbr),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .busy(busy), .resp_done(resp_done), .resp_retry(resp_retry),
        .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // page-table contents, by page number
    function automatic logic [7:0] pte_of(input int v);
        case (v)
            1:       return 8'hC5;  // valid, read only, PFN 5
            2:       return 8'h07;  // not valid
            3:       return 8'hA9;  // valid, write only, PFN 9
            6:       return 8'hEA;
            7:       return 8'hE3;
            8:       return 8'hEC;
            default: return 8'hE0 | 8'(15 - v);
        endcase
    endfunction

    logic [7:0] pt [256];

    // memory with latency 1..3
    int         walk_cnt = 0;
    int         mem_cnt = 0;
    bit         mem_pend = 0;
    logic [7:0] mem_addr_cap = 8'h00;
    logic [7:0] last_walk_addr = 8'h00;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_pend     = 0;
            mem_rd_valid = 1'b0;
        end else begin
            mem_rd_valid = 1'b0;
            if (mem_pend) begin
                mem_cnt--;
                if (mem_cnt == 0) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = pt[mem_addr_cap];
                    mem_pend     = 0;
                end
            end
            if (mem_rd_req) begin
                mem_pend       = 1;
                mem_cnt        = 1 + (walk_cnt % 3);
                walk_cnt++;
                mem_addr_cap   = mem_rd_addr;
                last_walk_addr = mem_rd_addr;
            end
        end
    end

    // behavioural reference model
    int m_ph = 0;
    int m_v[4], m_tag[4], m_pfn[4], m_prot[4];
    int m_rr = 0;
    int m_addr = 0, m_wr = 0, m_vpn = 0;
    int e_done = 0, e_retry = 0, e_fault = 0, e_paddr = 0;
    int mh, mslot, mok, mprot;

    initial for (int i = 0; i < 4; i++) m_v[i] = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = 0;
            m_rr = 0;
            for (int i = 0; i < 4; i++) m_v[i] = 0;
        end else begin
            case (m_ph)
                0: if (req_valid) begin
                    m_vpn  = int'(req_vaddr) / 16;
                    m_wr   = int'(req_write);
                    m_addr = (int'(ptbr) + m_vpn) % 256;
                    mh = -1;
                    for (int i = 0; i < 4; i++) if (m_v[i] != 0 && m_tag[i] == m_vpn) mh = i;
                    if (mh >= 0) begin
                        mok = (m_wr != 0) ? (m_prot[mh] % 2) : (m_prot[mh] / 2);
                        e_done = 1; e_retry = 0;
                        e_fault = (mok != 0) ? 0 : 1;
                        e_paddr = (mok != 0) ? m_pfn[mh] * 16 + int'(req_vaddr) % 16 : 0;
                        m_ph = 3;
                    end else begin
                        m_ph = 1;
                    end
                end
                1: m_ph = 2;
                2: if (mem_rd_valid) begin
                    mprot = int'(mem_rd_data[6:5]);
                    mok = (m_wr != 0) ? (mprot % 2) : (mprot / 2);
                    e_paddr = 0;
                    if (!mem_rd_data[7]) begin
                        e_done = 1; e_retry = 0; e_fault = 2;
                    end else if (mok == 0) begin
                        e_done = 1; e_retry = 0; e_fault = 1;
                    end else begin
                        e_done = 0; e_retry = 1; e_fault = 0;
                        mslot = -1;
                        for (int i = 0; i < 4; i++) if (m_v[i] == 0 && mslot < 0) mslot = i;
                        if (mslot < 0) mslot = m_rr;
                        m_rr = (m_rr + 1) % 4;
                        m_v[mslot] = 1; m_tag[mslot] = m_vpn;
                        m_pfn[mslot] = int'(mem_rd_data[3:0]); m_prot[mslot] = mprot;
                    end
                    m_ph = 3;
                end
                default: m_ph = 0;
            endcase
        end
        if (cyc > 50000) begin
            fails++;
            $display("FAIL R9 watchdog: actual %0d cycles expected below 50000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // every-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9", int'(busy), int'(m_ph != 0), "busy");
            chk("R4", int'(mem_rd_req), int'(m_ph == 1), "mem_rd_req (R8 slot use)");
            if (m_ph == 1) chk("R4", int'(mem_rd_addr), m_addr, "mem_rd_addr");
            chk("R11", int'(resp_done), (m_ph == 3) ? e_done : 0, "resp_done");
            chk("R7", int'(resp_retry), (m_ph == 3) ? e_retry : 0, "resp_retry");
            chk("R3", int'(resp_fault), (m_ph == 3) ? e_fault : 0, "resp_fault");
            chk("R2", int'(resp_paddr), (m_ph == 3) ? e_paddr : 0, "resp_paddr");
        end
    end

    // kind: 0 done without fault, 1 retry, 2 fault, 3 timeout
    task automatic do_req(input logic [7:0] va, input bit wr, input bit noise,
                          output int kind, output int flt, output int pa);
        int guard;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        if (noise) begin
            req_vaddr = ~va; req_write = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        guard = 0;
        while (!(resp_done || resp_retry) && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        kind = (guard >= 100) ? 3 : resp_retry ? 1 : (resp_fault != 2'd0) ? 2 : 0;
        flt  = int'(resp_fault);
        pa   = int'(resp_paddr);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", int'(busy), 0, "busy after reply");
    endtask

    task automatic expect_req(input string tag, input logic [7:0] va, input bit wr, input bit noise,
                              input int ekind, input int eflt, input int epa);
        int k, f, p;
        do_req(va, wr, noise, k, f, p);
        chk(tag, k, ekind, $sformatf("outcome kind for %0d", va));
        chk(tag, f, eflt, $sformatf("fault for %0d", va));
        chk(tag, p, epa, $sformatf("paddr for %0d", va));
    endtask

    function automatic int pa_of(input int va);
        return int'(pte_of(va / 16) & 8'h0F) * 16 + va % 16;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    int w0, k;
    bit exp_hit[10] = '{0, 1, 1, 0, 1, 1, 1, 0, 1, 1};

    initial begin
        for (int a = 0; a < 256; a++) pt[a] = 8'h00;
        for (int v = 0; v < 16; v++) begin
            pt[(8'h80 + v) % 256] = pte_of(v);
            pt[(8'hF8 + v) % 256] = pte_of(v);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", int'(busy), 0, "busy after reset");
        chk("R1", int'(resp_done), 0, "resp_done after reset");
        chk("R1", int'(resp_retry), 0, "resp_retry after reset");
        chk("R1", int'(mem_rd_req), 0, "mem_rd_req after reset");
        chk("R1", int'(resp_fault), 0, "resp_fault after reset");

        // R10 array walk, first pass from a cold store (R1: first access misses)
        for (int i = 0; i < 10; i++) begin
            int f, p;
            do_req(8'(100 + 4 * i), 1'b0, 1'b0, k, f, p);
            chk("R10", k, exp_hit[i] ? 0 : 1, $sformatf("first pass element %0d", i));
            if (k == 1) expect_req("R7", 8'(100 + 4 * i), 1'b0, 1'b0, 0, 0, pa_of(100 + 4 * i));
            else chk("R2", p, pa_of(100 + 4 * i), "paddr on first-pass hit");
        end
        // R10 second pass: all hits
        for (int i = 0; i < 10; i++)
            expect_req("R10", 8'(100 + 4 * i), 1'b0, 1'b0, 0, 0, pa_of(100 + 4 * i));

        // R3: read-only page, write on a hit faults without a walk
        expect_req("R7", 8'h1C, 1'b0, 1'b0, 1, 0, 0);
        expect_req("R2", 8'h1C, 1'b0, 1'b0, 0, 0, 8'h5C);
        w0 = walk_cnt;
        expect_req("R3", 8'h1C, 1'b1, 1'b0, 2, 1, 0);
        chk("R3", walk_cnt - w0, 0, "walks on protected hit");

        // R6: write-only page read faults via walk and is not installed
        w0 = walk_cnt;
        expect_req("R6", 8'h33, 1'b0, 1'b0, 2, 1, 0);
        expect_req("R6", 8'h33, 1'b0, 1'b0, 2, 1, 0);
        chk("R6", walk_cnt - w0, 2, "walks for repeated forbidden read");
        expect_req("R7", 8'h33, 1'b1, 1'b0, 1, 0, 0);
        expect_req("R7", 8'h33, 1'b1, 1'b0, 0, 0, 8'h93);

        // R5: invalid entry, segmentation fault, nothing installed
        w0 = walk_cnt;
        expect_req("R5", 8'h2A, 1'b0, 1'b0, 2, 2, 0);
        expect_req("R5", 8'h2A, 1'b1, 1'b0, 2, 2, 0);
        chk("R5", walk_cnt - w0, 2, "walks for invalid entry");

        // R8 replacement order
        do_reset();
        expect_req("R8", 8'h01, 1'b0, 1'b0, 1, 0, 0);
        expect_req("R8", 8'h41, 1'b0, 1'b0, 1, 0, 0);
        expect_req("R8", 8'h51, 1'b0, 1'b0, 1, 0, 0);
        expect_req("R8", 8'h91, 1'b0, 1'b0, 1, 0, 0);
        expect_req("R8", 8'hA1, 1'b1, 1'b0, 1, 0, 0);          // evicts slot 0 (page 0)
        expect_req("R8", 8'h42, 1'b0, 1'b0, 0, 0, pa_of(8'h42));
        expect_req("R8", 8'h02, 1'b0, 1'b0, 1, 0, 0);          // evicts slot 1 (page 4)
        expect_req("R8", 8'h52, 1'b0, 1'b0, 0, 0, pa_of(8'h52));
        expect_req("R8", 8'h43, 1'b0, 1'b0, 1, 0, 0);          // evicts slot 2 (page 5)
        expect_req("R8", 8'h93, 1'b0, 1'b0, 0, 0, pa_of(8'h93));
        expect_req("R8", 8'hA3, 1'b0, 1'b0, 0, 0, pa_of(8'hA3));

        // R9: requests held high while busy are ignored
        w0 = walk_cnt;
        expect_req("R9", 8'hB7, 1'b0, 1'b1, 1, 0, 0);
        chk("R9", walk_cnt - w0, 1, "walks during noisy miss");
        expect_req("R9", 8'hB7, 1'b1, 1'b1, 0, 0, pa_of(8'hB7));

        // R4: base plus page number wraps modulo 256
        @(negedge clk); ptbr = 8'hF8;
        expect_req("R4", 8'hC3, 1'b0, 1'b0, 1, 0, 0);
        chk("R4", int'(last_walk_addr), 8'h04, "wrapped walk address");
        expect_req("R4", 8'hC3, 1'b1, 1'b0, 0, 0, pa_of(8'hC3));

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule